// File: doc/BRIEF.md
# Interrupt Controller Mode Register

This block is the 64-bit base register that sets the operating mode of a local interrupt controller. It stores two mode bits (a unit enable and an extended-mode enable), a read-only flag marking the bootstrap processor, and a 24-bit physical base-address field. It is reached through a plain register port: a write strobe with 64-bit data, and a read strobe that returns the stored image as two registered 32-bit halves.

Every write is screened against the allowed mode moves before it lands. A write that would set a reserved bit, encode the invalid mode, leave extended mode other than by switching the unit off, or jump from off straight into extended mode is discarded. The block then pulses a fault output for one cycle and keeps its previous contents. The current mode is always driven on a dedicated output.

Top module: `intc_mode_reg`

## Requirements
- R1: After synchronous reset the mode is legacy (bit 11 = 1, bit 10 = 0), the base field at bits 35:12 holds the parameter BASE_DEFAULT, bit 8 holds the strap input, all other bits are zero, and fault is low.
- R2: A cycle with rd_en high registers the image: rd_lo carries bits 31:0 and rd_hi bits 63:32, both valid from the cycle after. A read in the same cycle as a write returns the contents from before that write.
- R3: The mode is {bit 11, bit 10}: 00 off, 10 legacy, 11 extended. The code 01 is never held, and a write carrying 01 faults in every mode.
- R4: While in extended mode (11), a write carrying mode 10 faults and is discarded.
- R5: While in extended mode, a write carrying 00 is accepted and turns the unit off. A write carrying 11 is accepted and updates the base field.
- R6: While off (00), a write carrying 11 faults and is discarded. A write carrying 10 is accepted.
- R7: While in legacy mode (10), a write carrying 11 is accepted and enters extended mode.
- R8: A write with any reserved bit set (bits 7:0, bit 9, bits 63:36) faults and is discarded, whatever the mode fields say.
- R9: Bit 8 always reads back the strap value captured at reset. Written data in bit 8 has no effect and causes no fault.
- R10: The fault output is high for exactly the one cycle that follows a rejected write. A rejected write leaves every field unchanged. An accepted write updates mode and base at the next clock edge and leaves fault low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bsp_strap | input | 1 | Bootstrap-processor strap, sampled during reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 64 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_lo | output | 32 | Registered read data, bits 31:0 |
| rd_hi | output | 32 | Registered read data, bits 63:32 |
| cur_mode | output | 2 | Current mode {unit enable, extended enable} |
| fault | output | 1 | One-cycle pulse for a rejected write |

## Verification
The assertions assume that wr_en and rd_en are known outside reset and that the bootstrap strap is steady while reset is high. They also treat the high read half as a full register image, so its reserved bits are expected to be zero after any read. The stimulus changes inputs only just after a falling edge, keeps each strobe to a single cycle per operation, and drives the strap only while reset is asserted. All mode moves, both legal and illegal, start from states that legal writes have reached.

// File: rtl/icm_pkg.sv
package icm_pkg;
  localparam int BSP_BIT  = 8;
  localparam int EXT_BIT  = 10;
  localparam int ON_BIT   = 11;
  localparam int BASE_LSB = 12;

  typedef enum logic [1:0] {
    M_OFF    = 2'b00,
    M_BAD    = 2'b01,
    M_LEGACY = 2'b10,
    M_EXT    = 2'b11
  } icm_mode_e;

  // bits a write must leave clear: everything outside base, mode bits and strap bit
  function automatic logic [63:0] rsv_mask(input int base_w);
    logic [63:0] keep;
    keep = (((64'h1 << base_w) - 64'h1) << BASE_LSB);
    keep[ON_BIT]  = 1'b1;
    keep[EXT_BIT] = 1'b1;
    keep[BSP_BIT] = 1'b1;
    return ~keep;
  endfunction
endpackage

// File: rtl/icm_xition_chk.sv
module icm_xition_chk
  import icm_pkg::*;
#(
  parameter int BASE_W = 24
) (
  input  icm_mode_e   cur,
  input  logic [63:0] wdata,
  output logic        accept
);
  localparam logic [63:0] RSV = rsv_mask(BASE_W);

  icm_mode_e nxt;
  logic      rsv_hit;

  always_comb begin
    nxt     = icm_mode_e'({wdata[ON_BIT], wdata[EXT_BIT]});
    rsv_hit = |(wdata & RSV);
    accept  = 1'b1;
    if (rsv_hit)                          accept = 1'b0;
    if (nxt == M_BAD)                     accept = 1'b0;
    if (cur == M_EXT && nxt == M_LEGACY)  accept = 1'b0;
    if (cur == M_OFF && nxt == M_EXT)     accept = 1'b0;
  end
endmodule

// File: rtl/icm_state_reg.sv
module icm_state_reg
  import icm_pkg::*;
#(
  parameter int                BASE_W       = 24,
  parameter logic [BASE_W-1:0] BASE_DEFAULT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bsp_strap,
  input  logic              wr_en,
  input  logic              accept,
  input  logic [63:0]       wdata,
  output icm_mode_e         mode_q,
  output logic [BASE_W-1:0] base_q,
  output logic              bsp_q,
  output logic              fault_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= M_LEGACY;
      base_q  <= BASE_DEFAULT;
      bsp_q   <= bsp_strap;
      fault_q <= 1'b0;
    end else begin
      fault_q <= wr_en & ~accept;
      if (wr_en && accept) begin
        mode_q <= icm_mode_e'({wdata[ON_BIT], wdata[EXT_BIT]});
        base_q <= wdata[BASE_LSB +: BASE_W];
      end
    end
  end
endmodule

// File: rtl/icm_read_port.sv
module icm_read_port #(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [2*HALF_W-1:0] image,
  output logic [HALF_W-1:0] rd_lo,
  output logic [HALF_W-1:0] rd_hi
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_lo <= '0;
      rd_hi <= '0;
    end else if (rd_en) begin
      rd_lo <= image[HALF_W-1:0];
      rd_hi <= image[2*HALF_W-1:HALF_W];
    end
  end
endmodule

// File: rtl/intc_mode_reg.sv
module intc_mode_reg
  import icm_pkg::*;
#(
  parameter int                BASE_W       = 24,
  parameter logic [BASE_W-1:0] BASE_DEFAULT = 24'h00FEE0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bsp_strap,
  input  logic        wr_en,
  input  logic [63:0] wr_data,
  input  logic        rd_en,
  output logic [31:0] rd_lo,
  output logic [31:0] rd_hi,
  output logic [1:0]  cur_mode,
  output logic        fault
);
  localparam int HALF_W = 32;

  icm_mode_e         mode_q;
  logic [BASE_W-1:0] base_q;
  logic              bsp_q;
  logic              accept;
  logic [63:0]       image;

  icm_xition_chk #(.BASE_W(BASE_W)) u_chk (
    .cur    (mode_q),
    .wdata  (wr_data),
    .accept (accept)
  );

  icm_state_reg #(.BASE_W(BASE_W), .BASE_DEFAULT(BASE_DEFAULT)) u_state (
    .clk       (clk),
    .rst       (rst),
    .bsp_strap (bsp_strap),
    .wr_en     (wr_en),
    .accept    (accept),
    .wdata     (wr_data),
    .mode_q    (mode_q),
    .base_q    (base_q),
    .bsp_q     (bsp_q),
    .fault_q   (fault)
  );

  always_comb begin
    image                       = '0;
    image[BASE_LSB +: BASE_W]   = base_q;
    image[ON_BIT]               = mode_q[1];
    image[EXT_BIT]              = mode_q[0];
    image[BSP_BIT]              = bsp_q;
  end

  icm_read_port #(.HALF_W(HALF_W)) u_rd (
    .clk   (clk),
    .rst   (rst),
    .rd_en (rd_en),
    .image (image),
    .rd_lo (rd_lo),
    .rd_hi (rd_hi)
  );

  assign cur_mode = mode_q;
endmodule

// File: rtl/icm_checker.sv
module icm_checker
  import icm_pkg::*;
#(
  parameter int BASE_W = 24
) (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic        rd_en,
  input logic [31:0] rd_lo,
  input logic [31:0] rd_hi,
  input logic [1:0]  cur_mode,
  input logic        fault
);
  localparam logic [63:0] RSV = rsv_mask(BASE_W);

  logic armed;
  always_ff @(posedge clk) armed <= ~rst;

  p_no_bad_code_r3: assert property (@(posedge clk) disable iff (rst)
    armed |-> cur_mode != 2'b01);

  p_ext_not_legacy_r4: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(cur_mode) == 2'b11) |-> cur_mode != 2'b10);

  p_off_not_ext_r6: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(cur_mode) == 2'b00) |-> cur_mode != 2'b11);

  p_fault_after_wr_r10: assert property (@(posedge clk) disable iff (rst)
    (armed && fault) |-> $past(wr_en));

  p_reject_holds_r10: assert property (@(posedge clk) disable iff (rst)
    (armed && fault) |-> cur_mode == $past(cur_mode));

  p_rsv_reads_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(rd_en)) |-> ({rd_hi, rd_lo} & RSV) == 64'h0);
endmodule

bind intc_mode_reg icm_checker #(.BASE_W(BASE_W)) u_icm_checker (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .rd_lo    (rd_lo),
  .rd_hi    (rd_hi),
  .cur_mode (cur_mode),
  .fault    (fault)
);

// File: tb/intc_mode_reg_test.sv
module intc_mode_reg_test;
  localparam logic [63:0] RSV = 64'hFFFF_FFF0_0000_02FF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bsp_strap = 1'b1;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_lo, rd_hi;
  logic [1:0]  cur_mode;
  logic        fault;

  intc_mode_reg uut (
    .clk(clk), .rst(rst), .bsp_strap(bsp_strap), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .cur_mode(cur_mode), .fault(fault)
  );

  always #5 clk = ~clk;

  typedef struct {
    bit          chk_rd;
    logic [31:0] lo;
    logic [31:0] hi;
    logic [1:0]  md;
    bit          flt;
    string       tag;
    int          due;
  } exp_t;

  exp_t        q[$];
  logic [63:0] img;
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  task automatic cmp(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: one operation per cycle, expected result queued for the next falling edge
  task automatic step(bit w, logic [63:0] d, bit r, string tag);
    exp_t       e;
    logic [1:0] nm;
    bit         ok;
    @(negedge clk); #1;
    wr_en = w; wr_data = d; rd_en = r;
    e.chk_rd = r; e.lo = img[31:0]; e.hi = img[63:32];
    e.tag = tag; e.due = cyc; e.flt = 0;
    if (w) begin
      nm = d[11:10];
      ok = 1;
      if ((d & RSV) != 0) ok = 0;
      if (nm == 2'b01) ok = 0;
      if (img[11:10] == 2'b11 && nm == 2'b10) ok = 0;
      if (img[11:10] == 2'b00 && nm == 2'b11) ok = 0;
      e.flt = !ok;
      if (ok) begin
        img[35:12] = d[35:12];
        img[11:10] = nm;
      end
    end
    e.md = img[11:10];
    q.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        cmp(e.tag, "fault", {63'h0, fault}, {63'h0, e.flt});
        cmp(e.tag, "mode", {62'h0, cur_mode}, {62'h0, e.md});
        if (e.chk_rd) begin
          cmp(e.tag, "rd_lo", {32'h0, rd_lo}, {32'h0, e.lo});
          cmp(e.tag, "rd_hi", {32'h0, rd_hi}, {32'h0, e.hi});
        end
      end
      cyc++;
    end
  end

  function automatic logic [63:0] wv(logic [23:0] base, logic [1:0] md, logic [11:0] extra);
    return {28'h0, base, 12'h0} | {52'h0, md, 10'h0} | {52'h0, extra};
  endfunction

  initial begin
    img = 64'h0000_0000_0FEE_0900;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset image and mode
    step(0, '0, 1, "R1");
    step(0, '0, 0, "R1");
    // R2: base reaches into the high half
    step(1, wv(24'hABCDEF, 2'b10, 12'h0), 0, "R2");
    step(0, '0, 1, "R2");
    // R2: read in the write cycle sees old contents, then new
    step(1, wv(24'h123456, 2'b10, 12'h0), 1, "R2");
    step(0, '0, 1, "R2");
    // R9: bit 8 write data ignored, no fault
    step(1, wv(24'h123456, 2'b10, 12'h100), 1, "R9");
    step(0, '0, 1, "R9");
    // R8: reserved bits
    step(1, wv(24'h777777, 2'b10, 12'h001), 0, "R8");
    step(0, '0, 1, "R8");
    step(1, wv(24'h777777, 2'b10, 12'h200), 0, "R8");
    step(1, wv(24'h777777, 2'b10, 12'h0) | 64'h0000_0100_0000_0000, 0, "R8");
    step(0, '0, 1, "R8");
    // R3: invalid code in legacy mode
    step(1, wv(24'h111111, 2'b01, 12'h0), 0, "R3");
    step(0, '0, 1, "R3");
    // R7: legacy to extended
    step(1, wv(24'h222222, 2'b11, 12'h0), 0, "R7");
    step(0, '0, 1, "R7");
    // R4: extended to legacy refused
    step(1, wv(24'h333333, 2'b10, 12'h0), 0, "R4");
    step(0, '0, 1, "R4");
    // R3: invalid code in extended mode
    step(1, wv(24'h333333, 2'b01, 12'h0), 0, "R3");
    // R5: extended to extended updates base
    step(1, wv(24'h444444, 2'b11, 12'h0), 0, "R5");
    step(0, '0, 1, "R5");
    // R5: extended to off
    step(1, wv(24'h555555, 2'b00, 12'h0), 0, "R5");
    step(0, '0, 1, "R5");
    // R6: off to extended refused, R3 invalid code while off
    step(1, wv(24'h666666, 2'b11, 12'h0), 0, "R6");
    step(1, wv(24'h666666, 2'b01, 12'h0), 0, "R3");
    step(0, '0, 1, "R6");
    // R6: off to legacy accepted
    step(1, wv(24'h888888, 2'b10, 12'h0), 0, "R6");
    // R10: rejected then accepted back to back, fault drops after one cycle
    step(1, wv(24'h999999, 2'b10, 12'h080), 0, "R10");
    step(1, wv(24'hAAAAAA, 2'b11, 12'h0), 0, "R10");
    step(0, '0, 1, "R10");
    step(0, '0, 0, "R10");
    step(0, '0, 0, "R10");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule